// File: doc/BRIEF.md
# Register Width Mode Controller

This block keeps the register-size state of a processor core that grows from an 8-bit emulation mode up to 32-bit registers. It holds two hidden section flags, called `sec16` and `sec8` here. Together they pick one of four sections: 8-bit legacy, 16-bit emulation, native-half and native-full. It also holds the visible status bits `M` (accumulator size) and `X` (index size), plus the carry and overflow flags. Carry and overflow live here because the exchange instruction trades them against the hidden section flags.

The instruction decoder drives one-cycle strobes into the block:
- an exchange strobe;
- set-bits and clear-bits strobes that share an 8-bit mask;
- a status-pull strobe with the byte taken from the stack;
- direct set and clear strobes for carry and overflow.

The block outputs the active accumulator width and index width, the status byte for a push, and the current carry and overflow. Every update takes effect on the clock edge that samples the strobe. The outputs are decoded combinationally from the registers, so they show the new state right after that edge.

Top module: `regsize_ctrl`

## Requirements
- R1: After reset, both hidden section flags, M and X read as 1. Carry and overflow are 0, both widths are 8 bits, and the status byte is 0x30.
- R2: With sec16=1 and sec8=1 (8-bit legacy section), both widths are 8 bits. Width encoding: 2'b00=8, 2'b01=16, 2'b10=32.
- R3: With sec16=1 and sec8=0 (16-bit emulation section), M=0 gives a 16-bit accumulator and X=0 gives 16-bit index registers. A bit at 1 gives 8 bits.
- R4: With sec16=0 and sec8=0 (native-half section), M=0 gives a 16-bit accumulator and X=0 gives 32-bit index registers. A bit at 1 gives 8 bits.
- R5: With sec16=0 and sec8=1 (native-full section), M=0 gives a 32-bit accumulator and X=0 gives 32-bit index registers. A bit at 1 gives 8 bits.
- R6: In the 8-bit legacy section, an exchange swaps only carry with sec8. Overflow and sec16 stay unchanged.
- R7: In any other section, an exchange swaps carry with sec8 and overflow with sec16 in the same cycle.
- R8: The set-bits strobe sets, and the clear-bits strobe clears, each status bit whose mask bit is 1. Mask bit 5 (0x20) is M, bit 4 (0x10) is X, bit 6 (0x40) is overflow and bit 0 (0x01) is carry.
- R9: The status byte has overflow at bit 6, M at bit 5, X at bit 4 and carry at bit 0, with all other bits 0. A pull loads M, X, overflow and carry from those positions and never changes the section.
- R10: While in the 8-bit legacy section, M and X read as 1. No set, clear or pull can clear them.
- R11: When an exchange arrives in the same cycle as a set, clear or pull, the exchange is applied first. The others then act on its result, applied in the order pull, set-bits, clear-bits.
- R12: Direct carry and overflow strobes act after all other updates in the same cycle. Set wins over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xchg_stb | input | 1 | Exchange strobe |
| setb_stb | input | 1 | Set status bits selected by `bit_mask` |
| clrb_stb | input | 1 | Clear status bits selected by `bit_mask` |
| bit_mask | input | 8 | Mask shared by the set and clear strobes |
| pull_stb | input | 1 | Load status from `pull_byte` |
| pull_byte | input | 8 | Status byte popped from the stack |
| c_set | input | 1 | Set carry |
| c_clr | input | 1 | Clear carry |
| v_set | input | 1 | Set overflow |
| v_clr | input | 1 | Clear overflow |
| acc_width | output | 2 | Accumulator width code |
| idx_width | output | 2 | Index register width code |
| status_out | output | 8 | Status byte for a push |
| carry_out | output | 1 | Current carry flag |
| ovf_out | output | 1 | Current overflow flag |

## Verification
Every strobe is registered on the rising edge that samples it. All outputs are then decoded combinationally, so each result is due exactly one edge after the stimulus. There is no further latency, not even for width changes caused by a section switch.

The driver applies a stimulus half a cycle before an edge. After that edge it queues the expected widths, status byte and flags. The monitor compares them at the following falling edge, away from any edge where they could change.

Reset is released through a two-stage synchronizer, so stimulus starts only a few cycles after reset is released.

// File: rtl/regsize_pkg.sv
package regsize_pkg;

  typedef enum logic [1:0] {
    WID_8  = 2'b00,
    WID_16 = 2'b01,
    WID_32 = 2'b10
  } width_e;

  typedef struct packed {
    logic sec16;
    logic sec8;
    logic m;
    logic x;
    logic c;
    logic v;
  } mode_flags_t;

endpackage

// File: rtl/regsize_rst_sync.sv
module regsize_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/regsize_flag_state.sv
module regsize_flag_state
  import regsize_pkg::*;
#(
  parameter int SW    = 8,
  parameter int M_POS = 5,
  parameter int X_POS = 4,
  parameter int V_POS = 6,
  parameter int C_POS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xchg_stb,
  input  logic          setb_stb,
  input  logic          clrb_stb,
  input  logic [SW-1:0] bit_mask,
  input  logic          pull_stb,
  input  logic [SW-1:0] pull_byte,
  input  logic          c_set,
  input  logic          c_clr,
  input  logic          v_set,
  input  logic          v_clr,
  output mode_flags_t   flags_q
);

  mode_flags_t flags_d;
  mode_flags_t after_xchg;
  mode_flags_t after_pull;
  mode_flags_t after_set;
  mode_flags_t after_clr;
  logic        legacy_now;
  logic        upd_en;

  assign legacy_now = flags_q.sec16 & flags_q.sec8;
  assign upd_en = xchg_stb | setb_stb | clrb_stb | pull_stb |
                  c_set | c_clr | v_set | v_clr;

  // Stage 1: exchange, whose effect depends on the current section
  always_comb begin
    after_xchg = flags_q;
    if (xchg_stb) begin
      after_xchg.sec8 = flags_q.c;
      after_xchg.c    = flags_q.sec8;
      if (!legacy_now) begin
        after_xchg.sec16 = flags_q.v;
        after_xchg.v     = flags_q.sec16;
      end
    end
  end

  // Stage 2: pull visible bits from the stack byte
  always_comb begin
    after_pull = after_xchg;
    if (pull_stb) begin
      after_pull.m = pull_byte[M_POS];
      after_pull.x = pull_byte[X_POS];
      after_pull.v = pull_byte[V_POS];
      after_pull.c = pull_byte[C_POS];
    end
  end

  // Stage 3: set masked bits
  always_comb begin
    after_set = after_pull;
    if (setb_stb) begin
      if (bit_mask[M_POS]) after_set.m = 1'b1;
      if (bit_mask[X_POS]) after_set.x = 1'b1;
      if (bit_mask[V_POS]) after_set.v = 1'b1;
      if (bit_mask[C_POS]) after_set.c = 1'b1;
    end
  end

  // Stage 4: clear masked bits
  always_comb begin
    after_clr = after_set;
    if (clrb_stb) begin
      if (bit_mask[M_POS]) after_clr.m = 1'b0;
      if (bit_mask[X_POS]) after_clr.x = 1'b0;
      if (bit_mask[V_POS]) after_clr.v = 1'b0;
      if (bit_mask[C_POS]) after_clr.c = 1'b0;
    end
  end

  // Stage 5: direct flag strobes (set dominates), then legacy forcing
  always_comb begin
    flags_d = after_clr;
    if (c_clr) flags_d.c = 1'b0;
    if (c_set) flags_d.c = 1'b1;
    if (v_clr) flags_d.v = 1'b0;
    if (v_set) flags_d.v = 1'b1;
    if (flags_d.sec16 && flags_d.sec8) begin
      flags_d.m = 1'b1;
      flags_d.x = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '{sec16: 1'b1, sec8: 1'b1, m: 1'b1, x: 1'b1, c: 1'b0, v: 1'b0};
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/regsize_width_dec.sv
module regsize_width_dec
  import regsize_pkg::*;
(
  input  mode_flags_t flags,
  output width_e      acc_w,
  output width_e      idx_w
);

  logic legacy;

  assign legacy = flags.sec16 & flags.sec8;

  always_comb begin
    if (legacy || flags.m)  acc_w = WID_8;
    else if (flags.sec16)   acc_w = WID_16;
    else if (flags.sec8)    acc_w = WID_32;
    else                    acc_w = WID_16;
  end

  always_comb begin
    if (legacy || flags.x)  idx_w = WID_8;
    else if (flags.sec16)   idx_w = WID_16;
    else                    idx_w = WID_32;
  end

endmodule

// File: rtl/regsize_status_pack.sv
module regsize_status_pack
  import regsize_pkg::*;
#(
  parameter int SW    = 8,
  parameter int M_POS = 5,
  parameter int X_POS = 4,
  parameter int V_POS = 6,
  parameter int C_POS = 0
) (
  input  mode_flags_t   flags,
  output logic [SW-1:0] status
);

  for (genvar b = 0; b < SW; b++) begin : g_bit
    if (b == M_POS) begin : g_m
      assign status[b] = flags.m;
    end else if (b == X_POS) begin : g_x
      assign status[b] = flags.x;
    end else if (b == V_POS) begin : g_v
      assign status[b] = flags.v;
    end else if (b == C_POS) begin : g_c
      assign status[b] = flags.c;
    end else begin : g_zero
      assign status[b] = 1'b0;
    end
  end

endmodule

// File: rtl/regsize_ctrl.sv
module regsize_ctrl
  import regsize_pkg::*;
#(
  parameter int SW          = 8,
  parameter int M_POS       = 5,
  parameter int X_POS       = 4,
  parameter int V_POS       = 6,
  parameter int C_POS       = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xchg_stb,
  input  logic          setb_stb,
  input  logic          clrb_stb,
  input  logic [SW-1:0] bit_mask,
  input  logic          pull_stb,
  input  logic [SW-1:0] pull_byte,
  input  logic          c_set,
  input  logic          c_clr,
  input  logic          v_set,
  input  logic          v_clr,
  output logic [1:0]    acc_width,
  output logic [1:0]    idx_width,
  output logic [SW-1:0] status_out,
  output logic          carry_out,
  output logic          ovf_out
);

  logic        rst_n_s;
  mode_flags_t flags;
  width_e      acc_w;
  width_e      idx_w;

  regsize_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  regsize_flag_state #(
    .SW(SW), .M_POS(M_POS), .X_POS(X_POS), .V_POS(V_POS), .C_POS(C_POS)
  ) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .xchg_stb  (xchg_stb),
    .setb_stb  (setb_stb),
    .clrb_stb  (clrb_stb),
    .bit_mask  (bit_mask),
    .pull_stb  (pull_stb),
    .pull_byte (pull_byte),
    .c_set     (c_set),
    .c_clr     (c_clr),
    .v_set     (v_set),
    .v_clr     (v_clr),
    .flags_q   (flags)
  );

  regsize_width_dec u_dec (
    .flags (flags),
    .acc_w (acc_w),
    .idx_w (idx_w)
  );

  regsize_status_pack #(
    .SW(SW), .M_POS(M_POS), .X_POS(X_POS), .V_POS(V_POS), .C_POS(C_POS)
  ) u_stat (
    .flags  (flags),
    .status (status_out)
  );

  assign acc_width = acc_w;
  assign idx_width = idx_w;
  assign carry_out = flags.c;
  assign ovf_out   = flags.v;

endmodule

// File: rtl/regsize_ctrl_chk.sv
module regsize_ctrl_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       sec16,
  input logic       sec8,
  input logic       m,
  input logic       x,
  input logic       c,
  input logic       v,
  input logic       xchg_stb,
  input logic       setb_stb,
  input logic       clrb_stb,
  input logic       pull_stb,
  input logic       c_set,
  input logic       c_clr,
  input logic       v_set,
  input logic       v_clr,
  input logic [1:0] acc_width,
  input logic [1:0] idx_width
);

  logic lone_xchg;
  logic lone_pull;
  assign lone_xchg = xchg_stb & ~setb_stb & ~clrb_stb & ~pull_stb &
                     ~c_set & ~c_clr & ~v_set & ~v_clr;
  assign lone_pull = pull_stb & ~xchg_stb;

  // R2
  legacy_width_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sec16 && sec8) |-> (acc_width == 2'b00 && idx_width == 2'b00));

  // R10
  legacy_mx_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sec16 && sec8) |-> (m && x));

  // R5
  full_acc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!sec16 && sec8 && !m) |-> (acc_width == 2'b10));

  // R4
  half_acc_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!sec16 && !sec8 && !m) |-> (acc_width == 2'b01));

  // R6
  legacy_xchg_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (lone_xchg && sec16 && sec8) |=>
      (sec8 == $past(c) && c == $past(sec8) && v == $past(v) && sec16));

  // R7
  wide_xchg_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (lone_xchg && !(sec16 && sec8)) |=>
      (sec8 == $past(c) && c == $past(sec8) &&
       sec16 == $past(v) && v == $past(sec16)));

  // R9
  pull_section_chk: assert property (@(posedge clk) disable iff (!srst_n)
    lone_pull |=> (sec16 == $past(sec16) && sec8 == $past(sec8)));

endmodule

bind regsize_ctrl regsize_ctrl_chk u_chk (
  .clk       (clk),
  .srst_n    (rst_n_s),
  .sec16     (flags.sec16),
  .sec8      (flags.sec8),
  .m         (flags.m),
  .x         (flags.x),
  .c         (flags.c),
  .v         (flags.v),
  .xchg_stb  (xchg_stb),
  .setb_stb  (setb_stb),
  .clrb_stb  (clrb_stb),
  .pull_stb  (pull_stb),
  .c_set     (c_set),
  .c_clr     (c_clr),
  .v_set     (v_set),
  .v_clr     (v_clr),
  .acc_width (acc_width),
  .idx_width (idx_width)
);

// File: tb/sim_regsize_ctrl.sv
module sim_regsize_ctrl;

  logic       clk;
  logic       rst_n;
  logic       xchg_stb, setb_stb, clrb_stb, pull_stb;
  logic [7:0] bit_mask, pull_byte;
  logic       c_set, c_clr, v_set, v_clr;
  logic [1:0] acc_width, idx_width;
  logic [7:0] status_out;
  logic       carry_out, ovf_out;

  regsize_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .xchg_stb(xchg_stb), .setb_stb(setb_stb),
    .clrb_stb(clrb_stb), .bit_mask(bit_mask), .pull_stb(pull_stb),
    .pull_byte(pull_byte), .c_set(c_set), .c_clr(c_clr), .v_set(v_set),
    .v_clr(v_clr), .acc_width(acc_width), .idx_width(idx_width),
    .status_out(status_out), .carry_out(carry_out), .ovf_out(ovf_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [1:0] acc;
    logic [1:0] idx;
    logic [7:0] st;
    logic       c;
    logic       v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // Reference model state
  logic s16, s8, mm, xx, cc, vv;

  function automatic logic [1:0] f_acc();
    if ((s16 && s8) || mm) return 2'b00;
    if (s16) return 2'b01;
    return s8 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] f_idx();
    if ((s16 && s8) || xx) return 2'b00;
    return s16 ? 2'b01 : 2'b10;
  endfunction

  task automatic step(input bit xg, input bit sb, input bit cb, input logic [7:0] mk,
                      input bit pl, input logic [7:0] pb,
                      input bit cs, input bit cr, input bit vs, input bit vr,
                      input string tag);
    exp_t e;
    logic t;
    @(negedge clk);
    xchg_stb = xg; setb_stb = sb; clrb_stb = cb; bit_mask = mk;
    pull_stb = pl; pull_byte = pb; c_set = cs; c_clr = cr; v_set = vs; v_clr = vr;
    @(posedge clk);
    if (xg) begin
      if (s16 && s8) begin
        t = s8; s8 = cc; cc = t;
      end else begin
        t = s8; s8 = cc; cc = t;
        t = s16; s16 = vv; vv = t;
      end
    end
    if (pl) begin mm = pb[5]; xx = pb[4]; vv = pb[6]; cc = pb[0]; end
    if (sb) begin
      if (mk[5]) mm = 1; if (mk[4]) xx = 1; if (mk[6]) vv = 1; if (mk[0]) cc = 1;
    end
    if (cb) begin
      if (mk[5]) mm = 0; if (mk[4]) xx = 0; if (mk[6]) vv = 0; if (mk[0]) cc = 0;
    end
    if (cr) cc = 0; if (cs) cc = 1;
    if (vr) vv = 0; if (vs) vv = 1;
    if (s16 && s8) begin mm = 1; xx = 1; end
    e.acc = f_acc(); e.idx = f_idx();
    e.st  = {1'b0, vv, mm, xx, 3'b000, cc};
    e.c = cc; e.v = vv; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    xchg_stb = 0; setb_stb = 0; clrb_stb = 0; pull_stb = 0;
    c_set = 0; c_clr = 0; v_set = 0; v_clr = 0;
  endtask

  // Monitor: compares at the falling edge after each expected update
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (acc_width !== e.acc || idx_width !== e.idx || status_out !== e.st ||
          carry_out !== e.c || ovf_out !== e.v) begin
        n_fail++;
        $display("FAIL %s: got acc=%b idx=%b st=%h c=%b v=%b, exp acc=%b idx=%b st=%h c=%b v=%b",
                 e.tag, acc_width, idx_width, status_out, carry_out, ovf_out,
                 e.acc, e.idx, e.st, e.c, e.v);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    xchg_stb = 0; setb_stb = 0; clrb_stb = 0; pull_stb = 0;
    bit_mask = 0; pull_byte = 0; c_set = 0; c_clr = 0; v_set = 0; v_clr = 0;
    s16 = 1; s8 = 1; mm = 1; xx = 1; cc = 0; vv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    //        xg sb cb mask  pl pbyte cs cr vs vr
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R1 reset state");
    step(0, 0, 1, 8'h30, 0, 8'h00, 0, 0, 0, 0, "R10 clear M/X in legacy");
    step(0, 0, 0, 8'h00, 1, 8'h00, 0, 0, 0, 0, "R10 R9 pull zero in legacy");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1, 0, "R12 overflow set");
    step(0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 0, 0, "R12 carry set wins");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 1, 0, 0, "R12 carry clear");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R6 legacy exchange carry only");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R2 R3 emulation 8/8");
    step(0, 0, 1, 8'h30, 0, 8'h00, 0, 0, 0, 0, "R3 emulation 16/16");
    step(0, 1, 0, 8'h10, 0, 8'h00, 0, 0, 0, 0, "R3 R8 emulation 16/8");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 1, "R12 overflow clear");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R7 exchange into native full");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R5 native full 32/8");
    step(0, 0, 1, 8'h10, 0, 8'h00, 0, 0, 0, 0, "R5 native full 32/32");
    step(0, 0, 1, 8'h41, 0, 8'h00, 0, 0, 0, 0, "R8 clear V and C by mask");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R7 exchange into native half");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R4 native half 16/32");
    step(0, 1, 0, 8'h20, 0, 8'h00, 0, 0, 0, 0, "R4 native half 8/32");
    step(0, 0, 0, 8'h00, 1, 8'h41, 0, 0, 0, 0, "R9 pull keeps section");
    step(0, 0, 0, 8'h00, 1, 8'h30, 0, 0, 0, 0, "R9 pull M/X high");
    step(0, 0, 0, 8'h00, 1, 8'h00, 0, 0, 0, 0, "R9 pull all low");
    step(0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 0, 0, "R12 carry set");
    step(1, 1, 0, 8'h01, 0, 8'h00, 0, 0, 0, 0, "R11 exchange before set");
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1, 0, "R12 overflow set");
    step(1, 0, 1, 8'h30, 0, 8'h00, 0, 0, 0, 0, "R11 R10 exchange to legacy then clear");
    step(0, 0, 0, 8'h00, 1, 8'h00, 0, 0, 0, 0, "R10 pull in legacy");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R6 legacy exchange again");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule